// File: doc/BRIEF.md
# Midpoint Current Sampler

This block decides when one phase current of a switching converter is converted by an ADC. It watches the phase's PWM signal. Each time the switch turns on or off, it loads a down-counter with half the length of the interval that has just begun. When the counter runs out, it sends a one-clock conversion request to the ADC. The two requests in a switching period therefore land in the middle of the rising ramp and the middle of the falling ramp of the inductor current. Both points are far from the switching transients.

The block tags each conversion with the ramp it belongs to and captures the result when the ADC reports done. It pairs the on-ramp result with the off-ramp result of the same period and publishes their mean as the average current for that period, together with a one-clock valid strobe. A mode input selects whether a high or a low PWM level means the switch is on. A second input selects whether the trigger output is active high or active low.

Top module: `midpoint_sampler`

## Requirements
- R1: The turn-on edge is sampled at clock edge 0. The ADC trigger then becomes active in the cycle that follows clock edge floor(duty/2)+1.
- R2: The turn-off edge is sampled at clock edge 0. The trigger then becomes active in the cycle that follows clock edge floor((period-duty)/2)+1.
- R3: When duty is equal to or greater than period, the off-interval half count is 0. The trigger then follows the turn-off edge after one clock edge.
- R4: A PWM edge that arrives while the counter is still running reloads the counter for the new interval. The pending request is dropped, and only one trigger results.
- R5: Each trigger is active for exactly one clock cycle.
- R6: With trig_active_high=1 the trigger is active at 1 and idles at 0. With trig_active_high=0 it is active at 0 and idles at 1.
- R7: With on_when_low=0 a rising PWM edge is the turn-on edge. With on_when_low=1 a falling PWM edge is the turn-on edge.
- R8: The published value is (a+b)>>1, where a is the on-ramp result and b is the off-ramp result. The sum is formed one bit wider than the data, so full-scale inputs do not wrap.
- R9: cur_valid is high for exactly one cycle, in the cycle after the clock edge that captures the off-ramp result. It rises only if an on-ramp result of the same period was captured. At all other times cur_avg holds its value.
- R10: After reset the trigger is idle, cur_valid is 0 and cur_avg is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pwm_in | input | 1 | PWM drive signal of the phase |
| duty | input | CW | On-time in clock cycles |
| period | input | CW | Switching period in clock cycles |
| on_when_low | input | 1 | 0: high PWM level means on; 1: low level means on |
| trig_active_high | input | 1 | Trigger polarity select |
| adc_data | input | DW | ADC conversion result |
| adc_done | input | 1 | One-cycle strobe: adc_data is valid |
| adc_trig | output | 1 | Conversion request |
| cur_avg | output | DW | Period-average current |
| cur_valid | output | 1 | One-cycle strobe for cur_avg |

## Verification
On every cycle, the assertions check the following:
- The trigger is a single-cycle pulse.
- A PWM edge never produces a trigger on the next cycle.
- The valid strobe never repeats on back-to-back cycles.
- The published mean lies between its two inputs.
- cur_avg only moves together with the strobe.

The bench scenarios are the only way to show the rest: the exact trigger delay for each half count, the clamp for an oversized duty, the dropped sample after an early edge, and the effect of the polarity and on-level modes.

// File: rtl/msamp_pkg.sv
`timescale 1ns/1ps
package msamp_pkg;
    typedef enum logic {
        SLOT_ON  = 1'b0,
        SLOT_OFF = 1'b1
    } slot_e;
endpackage

// File: rtl/msamp_timer.sv
`timescale 1ns/1ps
module msamp_timer
    import msamp_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwm_in,
    input  logic [CW-1:0] duty,
    input  logic [CW-1:0] period,
    input  logic          on_when_low,
    output logic          fire_o,
    output slot_e         fire_slot_o
);
    typedef struct packed {
        logic          pwm;
        logic [CW-1:0] cnt;
        logic          armed;
        slot_e         slot;
        logic          fire;
        slot_e         fire_slot;
    } tstate_t;

    tstate_t st_d, st_q;

    logic          edge_seen;
    logic          turn_on;
    logic [CW-1:0] off_span;
    logic [CW-1:0] half_on;
    logic [CW-1:0] half_off;

    always_comb begin
        edge_seen = (pwm_in != st_q.pwm);
        turn_on   = pwm_in ^ on_when_low;
        off_span  = (duty >= period) ? '0 : (period - duty);
        half_on   = duty >> 1;
        half_off  = off_span >> 1;

        st_d      = st_q;
        st_d.pwm  = pwm_in;
        st_d.fire = 1'b0;
        if (edge_seen) begin
            st_d.cnt   = turn_on ? half_on : half_off;
            st_d.armed = 1'b1;
            st_d.slot  = turn_on ? SLOT_ON : SLOT_OFF;
        end else if (st_q.armed) begin
            if (st_q.cnt == '0) begin
                st_d.fire      = 1'b1;
                st_d.fire_slot = st_q.slot;
                st_d.armed     = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fire_o      = st_q.fire;
    assign fire_slot_o = st_q.fire_slot;

    assert_trig_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o);

    assert_edge_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_in != st_q.pwm) |=> !fire_o);
endmodule

// File: rtl/msamp_pair.sv
`timescale 1ns/1ps
module msamp_pair
    import msamp_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire_i,
    input  slot_e         fire_slot_i,
    input  logic          adc_done,
    input  logic [DW-1:0] adc_data,
    output logic [DW-1:0] avg_o,
    output logic          valid_o
);
    localparam int SW = DW + 1;

    typedef struct packed {
        slot_e         tag;
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic          have_a;
        logic [DW-1:0] avg;
        logic          valid;
    } pstate_t;

    pstate_t       st_d, st_q;
    logic [SW-1:0] sum;

    always_comb begin
        sum        = {1'b0, st_q.a} + {1'b0, adc_data};
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (adc_done) begin
            if (st_q.tag == SLOT_ON) begin
                st_d.a      = adc_data;
                st_d.have_a = 1'b1;
            end else if (st_q.have_a) begin
                st_d.b      = adc_data;
                st_d.avg    = sum[SW-1:1];
                st_d.valid  = 1'b1;
                st_d.have_a = 1'b0;
            end
        end
        if (fire_i) begin
            st_d.tag = fire_slot_i;
            if (fire_slot_i == SLOT_ON) st_d.have_a = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign avg_o   = st_q.avg;
    assign valid_o = st_q.valid;

    assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    assert_avg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(avg_o));

    assert_avg_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ((avg_o >= ((st_q.a < st_q.b) ? st_q.a : st_q.b)) &&
                     (avg_o <= ((st_q.a < st_q.b) ? st_q.b : st_q.a))));
endmodule

// File: rtl/midpoint_sampler.sv
`timescale 1ns/1ps
module midpoint_sampler
    import msamp_pkg::*;
#(
    parameter int CW = 12,
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwm_in,
    input  logic [CW-1:0] duty,
    input  logic [CW-1:0] period,
    input  logic          on_when_low,
    input  logic          trig_active_high,
    input  logic [DW-1:0] adc_data,
    input  logic          adc_done,
    output logic          adc_trig,
    output logic [DW-1:0] cur_avg,
    output logic          cur_valid
);
    logic  fire;
    slot_e fire_slot;

    msamp_timer #(.CW(CW)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwm_in      (pwm_in),
        .duty        (duty),
        .period      (period),
        .on_when_low (on_when_low),
        .fire_o      (fire),
        .fire_slot_o (fire_slot)
    );

    msamp_pair #(.DW(DW)) u_pair (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire_i      (fire),
        .fire_slot_i (fire_slot),
        .adc_done    (adc_done),
        .adc_data    (adc_data),
        .avg_o       (cur_avg),
        .valid_o     (cur_valid)
    );

    assign adc_trig = trig_active_high ? fire : ~fire;
endmodule

// File: tb/sim_midpoint_sampler.sv
`timescale 1ns/1ps
module sim_midpoint_sampler;
    localparam int CW = 12;
    localparam int DW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwm_in = 1'b0;
    logic [CW-1:0] duty = '0;
    logic [CW-1:0] period = '0;
    logic          on_when_low = 1'b0;
    logic          trig_active_high = 1'b1;
    logic [DW-1:0] adc_data = '0;
    logic          adc_done = 1'b0;
    logic          adc_trig;
    logic [DW-1:0] cur_avg;
    logic          cur_valid;

    midpoint_sampler #(.CW(CW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .duty(duty), .period(period),
        .on_when_low(on_when_low), .trig_active_high(trig_active_high),
        .adc_data(adc_data), .adc_done(adc_done), .adc_trig(adc_trig),
        .cur_avg(cur_avg), .cur_valid(cur_valid)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int trig_n = 0;
    int trig_cyc = 0;
    int val_n = 0;
    int lat = 0;
    int t0 = 0;
    logic [DW-1:0] got_avg = '0;
    logic [DW-1:0] adc_val = '0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && (adc_trig == trig_active_high)) begin
            trig_n   = trig_n + 1;
            trig_cyc = cyc;
        end
        if (rst_n && cur_valid) begin
            val_n   = val_n + 1;
            got_avg = cur_avg;
        end
    end

    always @(negedge clk) begin
        adc_done <= 1'b0;
        if (lat != 0) begin
            lat <= lat - 1;
            if (lat == 1) begin
                adc_done <= 1'b1;
                adc_data <= adc_val;
            end
        end else if (rst_n && (adc_trig == trig_active_high)) begin
            lat <= 3;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic lvl);
        @(negedge clk);
        #1;
        pwm_in = lvl;
        t0 = cyc;
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    function automatic int exp_avg(input int a, input int b);
        return (a + b) >> 1;
    endfunction

    task automatic run_period(input int d, input int p, input int va, input int vb);
        int bt, bv, ta, tb;
        logic on_lvl;
        on_lvl = on_when_low ? 1'b0 : 1'b1;
        duty = d[CW-1:0];
        period = p[CW-1:0];
        bt = trig_n;
        bv = val_n;
        adc_val = va[DW-1:0];
        drive(on_lvl);
        ta = t0;
        waitc(d);
        check(trig_n == bt + 1, "R1/R5 on trig count", trig_n - bt, 1);
        check(trig_cyc - ta == d / 2 + 2, "R1/R7 on trig delay", trig_cyc - ta, d / 2 + 2);
        adc_val = vb[DW-1:0];
        drive(!on_lvl);
        tb = t0;
        waitc(p - d);
        check(trig_n == bt + 2, "R2/R5 off trig count", trig_n - bt, 2);
        check(trig_cyc - tb == (p - d) / 2 + 2, "R2 off trig delay", trig_cyc - tb, (p - d) / 2 + 2);
        check(val_n == bv + 1, "R9 valid count", val_n - bv, 1);
        check(got_avg == exp_avg(va, vb), "R8 average", got_avg, exp_avg(va, vb));
    endtask

    initial begin
        int seed;
        int bt, bv, ts;
        logic [DW-1:0] held;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        check(adc_trig == 1'b0, "R10 trig idle", adc_trig, 0);
        check(cur_valid == 1'b0, "R10 valid", cur_valid, 0);
        check(cur_avg == '0, "R10 avg", cur_avg, 0);
        #1 rst_n = 1'b1;
        waitc(4);

        // directed corner values
        run_period(40, 100, 4095, 4095);
        run_period(33, 80, 4095, 4094);
        run_period(16, 32, 0, 1);

        // random periods
        for (int i = 0; i < 40; i++) begin
            int p, d;
            p = $urandom_range(200, 40);
            d = $urandom_range(p - 16, 16);
            run_period(d, p, $urandom_range(4095, 0), $urandom_range(4095, 0));
        end

        // R4: early edge drops the pending on-ramp sample
        held = cur_avg;
        duty = 12'd60;
        period = 12'd100;
        bt = trig_n;
        bv = val_n;
        drive(1'b1);
        waitc(3);
        drive(1'b0);
        ts = t0;
        waitc(40);
        check(trig_n == bt + 1, "R4 single trig", trig_n - bt, 1);
        check(trig_cyc - ts == 22, "R4 reload delay", trig_cyc - ts, 22);
        check(val_n == bv, "R9 no valid without pair", val_n - bv, 0);
        check(cur_avg == held, "R9 avg held", cur_avg, held);
        run_period(50, 90, 100, 300);

        // R3: duty above period clamps off half count
        duty = 12'd50;
        period = 12'd30;
        drive(1'b1);
        waitc(40);
        bt = trig_n;
        drive(1'b0);
        ts = t0;
        waitc(20);
        check(trig_n == bt + 1, "R3 trig count", trig_n - bt, 1);
        check(trig_cyc - ts == 2, "R3 zero half", trig_cyc - ts, 2);

        // R6: active-low trigger
        trig_active_high = 1'b0;
        waitc(2);
        check(adc_trig == 1'b1, "R6 idle high", adc_trig, 1);
        run_period(24, 60, 1000, 3000);
        trig_active_high = 1'b1;
        waitc(2);
        check(adc_trig == 1'b0, "R6 idle low", adc_trig, 0);

        // R7: low level means on
        on_when_low = 1'b1;
        duty = 12'd20;
        period = 12'd60;
        drive(1'b1);
        waitc(60);
        for (int i = 0; i < 6; i++) begin
            int p, d;
            p = $urandom_range(150, 40);
            d = $urandom_range(p - 16, 16);
            run_period(d, p, $urandom_range(4095, 0), $urandom_range(4095, 0));
        end
        drive(1'b0);
        on_when_low = 1'b0;
        waitc(60);
        run_period(30, 70, 2048, 2049);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule